// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key Queue

This block scans an 8 by 8 key matrix on its own, so the processor never has to poll the keys. A free-running row counter drives an encoded scan output. The external row decoder uses that output to select one row at a time. The eight return inputs then show which columns of that row are closed.

A closure counts only when two successive scans of its row both see it. When it counts, the block captures the shift and control levels, forms a one-byte code and places the code in an eight-entry queue. The processor reads the queue one entry at a time, or reads a status byte that gives the fill level and a sticky overrun flag. An interrupt line stays high as long as the queue holds anything.

A mode input chooses between two policies. In lockout mode only the first key of a group that is down together is accepted. In rollover mode every key of the group is accepted and queued.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is asserted and after it is released, the scan output is 0, the interrupt is low and the status byte reads 0x00.
- R2: The scan output is 4 bits wide with the top bit at 0. Two cycles after reset is released the row counter begins counting. Each row then holds for 4 clock cycles, and the count steps 0,1,...,7 and wraps back to 0.
- R3: A queued code is {control, shift, row[2:0], column[2:0]}, with control in bit 7, shift in bit 6, row in bits 5:3 and column in bits 2:0. The shift and control levels are the ones present when the key is accepted.
- R4: A closure is accepted only after it has been seen on two successive scans of its row. A closure that lasts less than one scan period (32 cycles) is never queued.
- R5: A key held down is queued once. It can be queued again only after one scan has seen it released.
- R6: A data read (select 0) returns the oldest entry and removes it. Entries leave in the order they were accepted. A data read on an empty queue leaves the count at 0.
- R7: The interrupt output is high exactly while the queue holds at least one entry.
- R8: With mode 0 (lockout), a new key is refused while any other key is held. Once the held key is released, a still-pressed refused key is accepted.
- R9: With mode 1 (rollover), every pressed key is accepted. When several keys of one row become valid together, the lowest column is queued first and the next one follows on the next scan of that row.
- R10: When the queue holds 8 entries, a newly accepted key is dropped and the overrun flag (status bit 7) is set. A status read (select 1) returns the count in bits 3:0 and the flag in bit 7, and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ret_i | input | 8 | Column return lines, 1 = key closed in the selected row |
| shift_i | input | 1 | Shift key level |
| ctrl_i | input | 1 | Control key level |
| mode_i | input | 1 | 0 = lockout, 1 = rollover |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_sel_i | input | 1 | 0 = queue data, 1 = status |
| scan_o | output | 4 | Encoded row being scanned |
| rd_data_o | output | 8 | Read data for the selected source |
| irq_o | output | 1 | High while the queue is not empty |

## Verification
Faults in the per-key state show up at the status port within one to three scans (32 to 96 cycles). A stale candidate bit lets a short bounce reach the queue, so the fill count rises. A held bit that never clears blocks the key from being entered again. In lockout mode it also blocks every other key. Queue pointer or count faults show up at once, as codes out of order, an interrupt that drops with entries still present, or a missing overrun flag after the ninth key.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  typedef enum logic {
    KBD_LOCKOUT  = 1'b0,
    KBD_ROLLOVER = 1'b1
  } kbd_mode_e;
endpackage

// File: rtl/kbd_row_timer.sv
module kbd_row_timer #(
  parameter int ROWS  = 8,
  parameter int DWELL = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    sample_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int DIV_W = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [ROW_W-1:0] row_q, row_d;

  // the last cycle of a row's dwell is the sampling cycle
  assign sample_o = (div_q == DIV_W'(DWELL - 1));
  assign row_o    = row_q;

  always_comb begin
    div_d = sample_o ? '0 : div_q + 1'b1;
    row_d = row_q;
    if (sample_o) begin
      row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      row_q <= '0;
    end else begin
      div_q <= div_d;
      row_q <= row_d;
    end
  end

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |=> $stable(row_q));
  // R2
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && row_q == ROW_W'(ROWS - 1)) |=> (row_q == '0));
endmodule

// File: rtl/kbd_key_track.sv
module kbd_key_track #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int ENTRY_W = 2 + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COLS-1:0]    ret_i,
  input  logic               rollover_i,
  input  logic               shift_i,
  input  logic               ctrl_i,
  input  logic               full_i,
  output logic               push_o,
  output logic               drop_o,
  output logic [ENTRY_W-1:0] code_o
);
  logic [COLS-1:0]  cand_q [ROWS];
  logic [COLS-1:0]  cand_d [ROWS];
  logic [COLS-1:0]  held_q [ROWS];
  logic [COLS-1:0]  held_d [ROWS];
  logic [COLS-1:0]  fresh;
  logic [COLS-1:0]  pick_oh;
  logic [COL_W-1:0] pick_col;
  logic             pick_vld;
  logic             others_held;
  logic             accept;

  // pick the lowest newly confirmed column and judge the mode policy
  always_comb begin
    fresh    = ret_i & cand_q[row_i] & ~held_q[row_i];
    pick_vld = 1'b0;
    pick_col = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (fresh[c]) begin
        pick_vld = 1'b1;
        pick_col = COL_W'(c);
      end
    end
    pick_oh = pick_vld ? (COLS'(1) << pick_col) : '0;
    others_held = |(held_q[row_i] & ret_i);
    for (int r = 0; r < ROWS; r++) begin
      if (ROW_W'(r) != row_i) others_held = others_held | (|held_q[r]);
    end
    accept = sample_i & pick_vld & (rollover_i | ~others_held);
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      cand_d[r] = cand_q[r];
      held_d[r] = held_q[r];
    end
    if (sample_i) begin
      cand_d[row_i] = ret_i;
      held_d[row_i] = (held_q[row_i] & ret_i) | (accept ? pick_oh : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        cand_q[r] <= '0;
        held_q[r] <= '0;
      end
    end else if (sample_i) begin
      for (int r = 0; r < ROWS; r++) begin
        cand_q[r] <= cand_d[r];
        held_q[r] <= held_d[r];
      end
    end
  end

  assign push_o = accept & ~full_i;
  assign drop_o = accept & full_i;
  assign code_o = {ctrl_i, shift_i, row_i, pick_col};

  // R9
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o);
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R10
  push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R6
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q != '0 && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int DEPTH  = 8,
  parameter int DWELL  = 4,
  parameter int SCAN_W = 4,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int ENTRY_W = 2 + ROW_W + COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COLS-1:0]    ret_i,
  input  logic               shift_i,
  input  logic               ctrl_i,
  input  logic               mode_i,
  input  logic               rd_en_i,
  input  logic               rd_sel_i,
  output logic [SCAN_W-1:0]  scan_o,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               irq_o
);
  import kbd_scan_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic               rst_meta_q, rst_sync_q;
  logic [ROW_W-1:0]   row;
  logic               sample;
  logic               push, drop, full;
  logic [ENTRY_W-1:0] code, head;
  logic [CNT_W-1:0]   count;
  logic               ovr_q, ovr_d;
  logic               data_rd, stat_rd;
  logic [ENTRY_W-1:0] status;
  kbd_mode_e          mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign mode = kbd_mode_e'(mode_i);

  kbd_row_timer #(.ROWS(ROWS), .DWELL(DWELL)) u_timer (
    .clk(clk_i), .rst_n(rst_sync_q), .row_o(row), .sample_o(sample)
  );

  kbd_key_track #(.ROWS(ROWS), .COLS(COLS)) u_track (
    .clk(clk_i), .rst_n(rst_sync_q), .sample_i(sample), .row_i(row),
    .ret_i(ret_i), .rollover_i(mode == KBD_ROLLOVER), .shift_i(shift_i),
    .ctrl_i(ctrl_i), .full_i(full), .push_o(push), .drop_o(drop),
    .code_o(code)
  );

  assign data_rd = rd_en_i & ~rd_sel_i;
  assign stat_rd = rd_en_i & rd_sel_i;

  kbd_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk_i), .rst_n(rst_sync_q), .push_i(push), .data_i(code),
    .pop_i(data_rd), .head_o(head), .count_o(count), .full_o(full)
  );

  // a drop in the same cycle as a status read wins
  always_comb begin
    ovr_d = ovr_q;
    if (stat_rd) ovr_d = 1'b0;
    if (drop)    ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  always_comb begin
    status                 = '0;
    status[ENTRY_W-1]      = ovr_q;
    status[CNT_W-1:0]      = count;
  end

  assign rd_data_o = rd_sel_i ? status : head;
  assign scan_o    = SCAN_W'(row);
  assign irq_o     = (count != '0);

  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    $fell(irq_o) |-> $past(data_rd));
  // R10
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    $rose(ovr_q) |-> $past(drop));
endmodule

// File: tb/kbd_matrix_scanner_tb.sv
`timescale 1ns/1ps
module kbd_matrix_scanner_tb;
  localparam int SCAN = 32;

  // {ctrl, shift, row, col} stimulus and expected queued code
  localparam logic [15:0] VECS [6] = '{
    {8'h00, 8'h00}, {8'h3F, 8'h3F}, {8'h52, 8'h52},
    {8'hA9, 8'hA9}, {8'hDE, 8'hDE}, {8'h25, 8'h25}
  };

  logic       clk, rst_n;
  logic [7:0] ret;
  logic       shift, ctrl, mode, rd_en, rd_sel;
  logic [3:0] scan;
  logic [7:0] rd_data;
  logic       irq;
  logic [7:0] keys [8];
  int         checks, errors;
  logic [7:0] d;

  kbd_matrix_scanner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ret_i(ret), .shift_i(shift), .ctrl_i(ctrl),
    .mode_i(mode), .rd_en_i(rd_en), .rd_sel_i(rd_sel), .scan_o(scan),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb ret = keys[scan[2:0]];

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_scans(input int n);
    repeat (n * SCAN) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic key(input int r, input int c, input logic v);
    @(negedge clk);
    keys[r][c] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; shift = 0; ctrl = 0; mode = 0; rd_en = 0; rd_sel = 1;
    for (int r = 0; r < 8; r++) keys[r] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 scan in reset", int'(scan), 0);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 status in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 row0 dwell end", int'(scan), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 row1 step", int'(scan), 1);
    repeat (8) @(posedge clk); @(negedge clk);
    chk("R2 row3", int'(scan), 3);
    repeat (20) @(posedge clk); @(negedge clk);
    chk("R2 wrap to 0", int'(scan), 0);
    rd(1'b1, d);
    chk("R1 status after reset", int'(d), 0);

    // table of single keys: R3 format, R6 read, R7 irq
    for (int i = 0; i < 6; i++) begin
      logic [7:0] s;
      s = VECS[i][15:8];
      @(negedge clk); ctrl = s[7]; shift = s[6];
      key(int'(s[5:3]), int'(s[2:0]), 1'b1);
      wait_scans(3);
      key(int'(s[5:3]), int'(s[2:0]), 1'b0);
      wait_scans(2);
      chk("R7 irq with entry", int'(irq), 1);
      rd(1'b1, d); chk("R6 count one", int'(d), 1);
      rd(1'b0, d); chk("R3 code", int'(d), int'(VECS[i][7:0]));
      chk("R7 irq empty", int'(irq), 0);
      ctrl = 0; shift = 0;
    end

    // R4 bounce shorter than a scan
    key(1, 1, 1'b1);
    repeat (10) @(posedge clk);
    key(1, 1, 1'b0);
    wait_scans(3);
    rd(1'b1, d); chk("R4 bounce ignored", int'(d), 0);

    // R5 held once, re-entry after release
    @(negedge clk); shift = 1;
    key(6, 7, 1'b1); wait_scans(8);
    rd(1'b1, d); chk("R5 held key once", int'(d), 1);
    key(6, 7, 1'b0); wait_scans(2);
    key(6, 7, 1'b1); wait_scans(3);
    key(6, 7, 1'b0); wait_scans(2);
    rd(1'b1, d); chk("R5 re-entry", int'(d), 2);
    rd(1'b0, d); chk("R5 first code", int'(d), 8'h77);
    rd(1'b0, d); chk("R5 second code", int'(d), 8'h77);
    shift = 0;

    // R8 lockout
    key(2, 1, 1'b1); wait_scans(3);
    key(5, 4, 1'b1); wait_scans(3);
    rd(1'b1, d); chk("R8 second key refused", int'(d), 1);
    key(2, 1, 1'b0); wait_scans(3);
    rd(1'b1, d); chk("R8 accepted after release", int'(d), 2);
    key(5, 4, 1'b0); wait_scans(2);
    rd(1'b0, d); chk("R8 first code", int'(d), 8'h11);
    rd(1'b0, d); chk("R8 second code", int'(d), 8'h2C);

    // R9 rollover, same row
    @(negedge clk); mode = 1;
    @(negedge clk); keys[3][6] = 1'b1; keys[3][2] = 1'b1;
    wait_scans(4);
    rd(1'b1, d); chk("R9 both queued", int'(d), 2);
    @(negedge clk); keys[3][6] = 1'b0; keys[3][2] = 1'b0;
    wait_scans(2);
    rd(1'b0, d); chk("R9 low column first", int'(d), 8'h1A);
    rd(1'b0, d); chk("R9 high column next", int'(d), 8'h1E);

    // R10 full and overrun, R6 order
    for (int k = 0; k < 9; k++) begin
      int r, c;
      r = (k < 8) ? k : 4;
      c = (k < 8) ? 3 : 5;
      key(r, c, 1'b1); wait_scans(3);
      key(r, c, 1'b0); wait_scans(1);
    end
    chk("R7 irq when full", int'(irq), 1);
    rd(1'b1, d); chk("R10 full with overrun", int'(d), 8'h88);
    rd(1'b1, d); chk("R10 overrun cleared", int'(d), 8'h08);
    for (int k = 0; k < 8; k++) begin
      rd(1'b0, d); chk("R6 order", int'(d), (k << 3) | 3);
    end
    rd(1'b0, d);
    rd(1'b1, d); chk("R6 empty read count stays 0", int'(d), 0);
    chk("R7 irq low at end", int'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule